// File: doc/BRIEF.md
# I2C Bus Error Detector

This block watches the two I2C lines for a START or STOP condition that appears where the frame does not allow one. A condition is illegal when it lands inside a byte, that is, on any address bit, data bit or the acknowledge slot. The block samples SDA and SCL through a two-stage synchroniser and finds the conditions from edges of the sampled levels. The transfer engine tells it two things: whether the controller is taking part in the transfer (as active master or as addressed slave), and where in the byte the transfer currently is.

When an illegal condition arrives while the controller is taking part, the block sends one-cycle commands that force the engine into not-addressed slave mode and make it release SDA and SCL. It also raises a sticky interrupt flag and loads the status code 0x00. The flag and the code hold until software clears them, and the status code then returns to the idle value 0xF8. Conditions seen while the controller is not taking part, or between bytes, cause none of this.

Top module: `i2c_buserr_det`

## Requirements
- R1: A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high, both judged on the synchronised levels. When an illegal condition is detected, bus_err_o is high for exactly one cycle, starting after the third rising clock edge that follows the SDA change at the pins.
- R2: A position is illegal when frame_active_i is 1 and bit_pos_i is between 0 and 8, where 0 to 7 are the address or data bits and 8 is the acknowledge slot. With frame_active_i at 0, or with bit_pos_i above 8, a condition is legal and causes no reaction.
- R3: An illegal condition is acted on only while involved_i is 1. With involved_i at 0, the outputs are not affected.
- R4: In the same cycle as bus_err_o, the outputs nas_mode_o, rel_sda_o and rel_scl_o each pulse high for one cycle.
- R5: On a bus error, irq_o becomes 1 and status_o becomes 0x00.
- R6: irq_o and status_o hold their values until irq_clr_i is sampled high. A clear sets irq_o to 0 and status_o to 0xF8. If a clear and an error fall in the same cycle, the error wins.
- R7: After reset, irq_o is 0, status_o is 0xF8, and all pulse outputs are 0.
- R8: An SDA change while SCL is low, or an SCL change while SDA is steady, is not a condition and causes no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Raw SDA line level |
| scl_i | input | 1 | Raw SCL line level |
| involved_i | input | 1 | Controller is active master or addressed slave |
| frame_active_i | input | 1 | Transfer engine is inside a byte |
| bit_pos_i | input | 4 | Current bit slot in the byte (0-7 bits, 8 acknowledge) |
| irq_clr_i | input | 1 | Software clear of the interrupt flag and the status code |
| bus_err_o | output | 1 | One-cycle bus-error pulse |
| nas_mode_o | output | 1 | Forces the engine into not-addressed slave mode |
| rel_sda_o | output | 1 | Command to release SDA |
| rel_scl_o | output | 1 | Command to release SCL |
| irq_o | output | 1 | Sticky interrupt flag |
| status_o | output | 8 | Status code: 0x00 after a bus error, 0xF8 when idle |

## Verification
The assertions check on every cycle that an error pulse is raised only after the controller was involved inside a byte, that the pulse comes with the flag set and a status of 0x00, that the flag stays set until a clear, that the status code changes only on an error or a clear, and that it only ever holds one of its two values. The bench scenarios show things a per-cycle property cannot. These are the exact three-edge latency from the pins, the full decision table over involvement, frame activity, every bit position and both condition types, and the fact that an SDA change under a low SCL produces nothing. They also show that the error wins when it meets a clear in the same cycle.

// File: rtl/i2c_berr_pkg.sv
package i2c_berr_pkg;
  localparam logic [7:0] ST_BUS_ERR = 8'h00;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  typedef struct packed {
    logic start;
    logic stop;
  } cond_t;
endpackage

// File: rtl/i2c_berr_sync.sv
module i2c_berr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '1;  // idle bus is high
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_berr_cond.sv
module i2c_berr_cond
  import i2c_berr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sda_s_i,
  input  logic  scl_s_i,
  output cond_t cond_o
);
  logic sda_q, scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_s_i;
      scl_q <= scl_s_i;
    end
  end

  // SCL must be high before and after the SDA edge
  logic scl_hi;
  assign scl_hi       = scl_q & scl_s_i;
  assign cond_o.start = scl_hi & sda_q & ~sda_s_i;
  assign cond_o.stop  = scl_hi & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_berr_ctrl.sv
module i2c_berr_ctrl
  import i2c_berr_pkg::*;
#(
  parameter int POS_W    = 4,
  parameter int LAST_POS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cond_t            cond_i,
  input  logic             involved_i,
  input  logic             frame_active_i,
  input  logic [POS_W-1:0] bit_pos_i,
  input  logic             irq_clr_i,
  output logic             err_o,
  output logic             irq_o,
  output logic [7:0]       status_o
);
  localparam logic [POS_W-1:0] LastPos = POS_W'(LAST_POS);

  logic in_byte, err_d;
  assign in_byte = frame_active_i && (bit_pos_i <= LastPos);
  assign err_d   = (cond_i.start | cond_i.stop) & involved_i & in_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o    <= 1'b0;
      irq_o    <= 1'b0;
      status_o <= ST_IDLE;
    end else begin
      err_o <= err_d;
      if (err_d) begin  // error wins over a simultaneous clear
        irq_o    <= 1'b1;
        status_o <= ST_BUS_ERR;
      end else if (irq_clr_i) begin
        irq_o    <= 1'b0;
        status_o <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/i2c_buserr_det.sv
module i2c_buserr_det
  import i2c_berr_pkg::*;
#(
  parameter int POS_W       = 4,
  parameter int LAST_POS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_i,
  input  logic             involved_i,
  input  logic             frame_active_i,
  input  logic [POS_W-1:0] bit_pos_i,
  input  logic             irq_clr_i,
  output logic             bus_err_o,
  output logic             nas_mode_o,
  output logic             rel_sda_o,
  output logic             rel_scl_o,
  output logic             irq_o,
  output logic [7:0]       status_o
);
  logic [1:0] lines_s;
  cond_t      cond;
  logic       err;

  i2c_berr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  i2c_berr_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sda_s_i(lines_s[0]),
    .scl_s_i(lines_s[1]),
    .cond_o (cond)
  );

  i2c_berr_ctrl #(.POS_W(POS_W), .LAST_POS(LAST_POS)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cond_i        (cond),
    .involved_i    (involved_i),
    .frame_active_i(frame_active_i),
    .bit_pos_i     (bit_pos_i),
    .irq_clr_i     (irq_clr_i),
    .err_o         (err),
    .irq_o         (irq_o),
    .status_o      (status_o)
  );

  assign bus_err_o  = err;
  assign nas_mode_o = err;
  assign rel_sda_o  = err;
  assign rel_scl_o  = err;
endmodule

// File: rtl/i2c_buserr_det_chk.sv
module i2c_buserr_det_chk
  import i2c_berr_pkg::*;
#(
  parameter int POS_W    = 4,
  parameter int LAST_POS = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             involved_i,
  input logic             frame_active_i,
  input logic [POS_W-1:0] bit_pos_i,
  input logic             irq_clr_i,
  input logic             bus_err_o,
  input logic             irq_o,
  input logic [7:0]       status_o
);
  a_r2_r3_err_needs_context: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> $past(involved_i && frame_active_i && (bit_pos_i <= POS_W'(LAST_POS))));

  a_r5_err_sets_flag_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (irq_o && status_o == ST_BUS_ERR));

  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  a_r6_status_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_o) |-> (bus_err_o || $past(irq_clr_i)));

  a_r7_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_BUS_ERR) || (status_o == ST_IDLE));
endmodule

bind i2c_buserr_det i2c_buserr_det_chk #(.POS_W(POS_W), .LAST_POS(LAST_POS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .involved_i    (involved_i),
  .frame_active_i(frame_active_i),
  .bit_pos_i     (bit_pos_i),
  .irq_clr_i     (irq_clr_i),
  .bus_err_o     (bus_err_o),
  .irq_o         (irq_o),
  .status_o      (status_o)
);

// File: tb/i2c_buserr_det_tb.sv
module i2c_buserr_det_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sda = 1'b1, scl = 1'b1;
  logic involved = 1'b0, frame_active = 1'b0, irq_clr = 1'b0;
  logic [3:0] bit_pos = '0;
  logic bus_err, nas_mode, rel_sda, rel_scl, irq;
  logic [7:0] status;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_buserr_det dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sda_i(sda), .scl_i(scl),
    .involved_i(involved), .frame_active_i(frame_active), .bit_pos_i(bit_pos),
    .irq_clr_i(irq_clr), .bus_err_o(bus_err), .nas_mode_o(nas_mode),
    .rel_sda_o(rel_sda), .rel_scl_o(rel_scl), .irq_o(irq), .status_o(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  // Bring lines to SDA=lvl, SCL=1 without making a condition
  task automatic park(input logic lvl);
    @(negedge clk) scl = 1'b0;
    wait_n(3);
    sda = lvl;
    wait_n(3);
    scl = 1'b1;
    wait_n(3);
  endtask

  // Issue a condition (start when is_start) and check the latency and pulse shape
  task automatic fire(input bit is_start, input bit exp_err, input string req);
    park(is_start ? 1'b1 : 1'b0);
    @(negedge clk) sda = is_start ? 1'b0 : 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk({req, " R1 early"}, {31'b0, bus_err}, 32'd0);
    @(negedge clk);
    chk({req, " R1 pulse"}, {31'b0, bus_err}, {31'b0, exp_err});
    chk({req, " R4 cmds"}, {29'b0, nas_mode, rel_sda, rel_scl}, exp_err ? 32'd7 : 32'd0);
    chk({req, " R5 irq"}, {31'b0, irq}, {31'b0, exp_err});
    chk({req, " R5 status"}, {24'b0, status}, exp_err ? 32'h00 : 32'hF8);
    @(negedge clk);
    chk({req, " R1 one cycle"}, {31'b0, bus_err}, 32'd0);
  endtask

  initial begin
    wait_n(2);
    chk("R7 irq", {31'b0, irq}, 32'd0);
    chk("R7 status", {24'b0, status}, 32'hF8);
    chk("R7 pulses", {28'b0, bus_err, nas_mode, rel_sda, rel_scl}, 32'd0);
    rst_ni = 1'b1;
    wait_n(3);

    // R2 / R3 sweep
    for (int inv = 0; inv < 2; inv++)
      for (int fa = 0; fa < 2; fa++)
        for (int pos = 0; pos < 11; pos++)
          for (int st = 0; st < 2; st++) begin
            bit e;
            involved = inv[0];
            frame_active = fa[0];
            bit_pos = pos[3:0];
            e = inv[0] && fa[0] && (pos <= 8);
            fire(st[0], e, inv[0] ? "R2" : "R3");
            if (e) begin
              wait_n(10);
              chk("R6 sticky irq", {31'b0, irq}, 32'd1);
              chk("R6 sticky status", {24'b0, status}, 32'h00);
              do_clear();
              chk("R6 clear irq", {31'b0, irq}, 32'd0);
              chk("R6 clear status", {24'b0, status}, 32'hF8);
            end
          end

    // R6: clear in the same cycle as the error, error wins
    involved = 1'b1; frame_active = 1'b1; bit_pos = 4'd3;
    park(1'b1);
    @(negedge clk) sda = 1'b0;
    @(negedge clk);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    chk("R6 err wins irq", {31'b0, irq}, 32'd1);
    chk("R6 err wins status", {24'b0, status}, 32'h00);
    do_clear();

    // R8: SDA toggles under low SCL, SCL toggles with SDA steady
    involved = 1'b1; frame_active = 1'b1; bit_pos = 4'd8;
    park(1'b1);
    @(negedge clk) scl = 1'b0;
    for (int k = 0; k < 6; k++) begin
      wait_n(3);
      sda = ~sda;
    end
    for (int k = 0; k < 6; k++) begin
      wait_n(3);
      scl = ~scl;
    end
    wait_n(5);
    chk("R8 no irq", {31'b0, irq}, 32'd0);
    chk("R8 status idle", {24'b0, status}, 32'hF8);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule